// File: doc/BRIEF.md
# Filtered Pin Edge Interrupt Port

This block monitors a group of port pins and turns qualified edges into a single interrupt request shared by the whole group. Each pin first passes through a synchronizer and then through a digital pulse filter running on the bus clock. A pin counts as having a valid event only when it has stayed at its selected active level for a minimum number of consecutive cycles. Shorter excursions are treated as glitches and discarded.

Each pin has three pieces of state. An enable bit decides whether the pin may raise the interrupt. A polarity bit picks a rising or a falling edge. A sticky flag records that a valid event happened. Software sets the enable and polarity registers through a small register interface and clears flags by writing ones to them. The block also has a wake output. It asserts while the interrupt request is active and the core reports a low-power state.

The filter counts only after it has seen the pin at its inactive level. A level that is already present after reset, or after a polarity change, is therefore never reported as an edge.

Top module: `edge_irq_port`

## Requirements
- R1: After reset, the enable, polarity and flag registers read as zero, and `irq_o` and `wake_o` are low.
- R2: The register address selects the register. Address 0 is the enable register, address 1 the polarity register (bit value 1 selects a rising edge, 0 a falling edge), address 2 the flag register, and address 3 reads as zero. Enable and polarity read back what was written.
- R3: When a rising-polarity pin is held high for 4 or more consecutive bus clocks, that pin's flag bit is set.
- R4: A pulse at the active level that lasts 3 bus clocks or fewer sets no flag.
- R5: On a falling-polarity pin, a low pulse of 4 or more cycles sets the flag. A high level on that pin, however long, sets nothing.
- R6: A pin held at its active level sets its flag once. If the flag is cleared while the level is still held, it stays clear until the pin goes inactive and then becomes active again.
- R7: Flags are set whatever the enable bits hold. `irq_o` is high exactly when some pin has both its flag bit and its enable bit set.
- R8: Writing to the flag register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R9: If a pin's event and a clear of that pin's flag fall in the same cycle, the flag ends up set.
- R10: A pin already at its active level when reset ends, or when its polarity bit changes, does not set its flag until it has gone inactive and then active again.
- R11: `wake_o` is high exactly when `irq_o` is high and `lowpwr_i` is high.
- R12: Pins are filtered independently, so valid pulses on several pins in the same cycles set each of their flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pins_i | input | NPINS | Pad levels of the monitored pins |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | NPINS | Register write data |
| reg_rdata_o | output | NPINS | Register read data for the selected register |
| lowpwr_i | input | 1 | Core is in a stop or wait state |
| irq_o | output | 1 | Shared interrupt request |
| wake_o | output | 1 | Wake-up request |

## Verification
The bench drives pulses of exactly 3 and 4 cycles. An off-by-one filter would either reject the 4-cycle pulse or accept the 3-cycle one. It times a clear write to land in the same cycle as a filter hit, which catches a register where the clear wins. It also changes polarity under a level that is already active and holds a pin active across a clear. A filter that counts levels instead of edges would set a spurious flag in either case. Enable masking and the wake gating are checked against the low-power input in both states.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    localparam int unsigned REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_ENABLE   = 2'd0,
        REG_POLARITY = 2'd1,
        REG_FLAGS    = 2'd2,
        REG_SPARE    = 2'd3
    } reg_sel_e;

    // Filter states: BLOCKED waits for the inactive level before arming,
    // READY is armed, COUNT accumulates active cycles, HELD has reported.
    typedef enum logic [1:0] {
        F_BLOCKED = 2'd0,
        F_READY   = 2'd1,
        F_COUNT   = 2'd2,
        F_HELD    = 2'd3
    } filt_state_e;

    // A rising-polarity pin is active when high, a falling one when low.
    function automatic logic level_active(input logic lvl, input logic rising);
        return (lvl == rising);
    endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) chain_q[0] <= '0;
        else       chain_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (rst_i) chain_q[s] <= '0;
            else       chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/eirq_filter.sv
module eirq_filter
    import eirq_pkg::*;
#(
    parameter int unsigned VALID_CYCLES = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic level_i,
    input  logic rising_i,
    output logic hit_o
);

    localparam int unsigned CNT_W = $clog2(VALID_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(VALID_CYCLES - 1);

    filt_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             rising_q;
    logic             active;
    logic             pol_chg;
    logic             hit;

    assign active  = level_active(level_i, rising_i);
    assign pol_chg = (rising_i != rising_q);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hit     = 1'b0;
        if (pol_chg) begin
            state_d = F_BLOCKED;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                F_BLOCKED: begin
                    if (!active) state_d = F_READY;
                end
                F_READY: begin
                    if (active) begin
                        state_d = F_COUNT;
                        cnt_d   = CNT_W'(1);
                    end
                end
                F_COUNT: begin
                    if (!active) begin
                        state_d = F_READY;
                        cnt_d   = '0;
                    end else if (cnt_q == LAST) begin
                        hit     = 1'b1;
                        state_d = F_HELD;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                F_HELD: begin
                    if (!active) state_d = F_READY;
                end
                default: begin
                    state_d = F_BLOCKED;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q  <= F_BLOCKED;
            cnt_q    <= '0;
            rising_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            rising_q <= rising_i;
        end
    end

    assign hit_o = hit;

    // R4: the counter never reaches the valid length itself
    a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q < CNT_W'(VALID_CYCLES));

    // R6: one held level gives a single event
    a_r6_single_hit: assert property (@(posedge clk_i) disable iff (rst_i)
        hit_o |=> !hit_o);

    // R10: a polarity change cannot be followed at once by an event
    a_r10_polchg_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        pol_chg |=> !hit_o);

    // R4: an inactive level leaves the counter empty
    a_r4_inactive_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        (!active && !pol_chg) |=> (cnt_q == '0));

endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
    import eirq_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  wr_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [NPINS-1:0]      wdata_i,
    input  logic [NPINS-1:0]      set_i,
    output logic [NPINS-1:0]      en_o,
    output logic [NPINS-1:0]      pol_o,
    output logic [NPINS-1:0]      flag_o,
    output logic [NPINS-1:0]      rdata_o
);

    reg_sel_e         sel;
    logic [NPINS-1:0] en_q, pol_q, flag_q;
    logic [NPINS-1:0] clr;

    assign sel = reg_sel_e'(addr_i);
    assign clr = (wr_i && sel == REG_FLAGS) ? wdata_i : '0;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            en_q   <= '0;
            pol_q  <= '0;
            flag_q <= '0;
        end else begin
            if (wr_i && sel == REG_ENABLE)   en_q  <= wdata_i;
            if (wr_i && sel == REG_POLARITY) pol_q <= wdata_i;
            // set after clear: an event in the clearing cycle survives
            flag_q <= (flag_q & ~clr) | set_i;
        end
    end

    always_comb begin
        unique case (sel)
            REG_ENABLE:   rdata_o = en_q;
            REG_POLARITY: rdata_o = pol_q;
            REG_FLAGS:    rdata_o = flag_q;
            default:      rdata_o = '0;
        endcase
    end

    assign en_o   = en_q;
    assign pol_o  = pol_q;
    assign flag_o = flag_q;

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        // R3: a flag only rises because its filter reported
        a_r3_flag_cause: assert property (@(posedge clk_i) disable iff (rst_i)
            $rose(flag_q[i]) |-> $past(set_i[i]));
        // R9: an event always leaves the flag set
        a_r9_set_wins: assert property (@(posedge clk_i) disable iff (rst_i)
            set_i[i] |=> flag_q[i]);
        // R8: a clear with no event empties the bit
        a_r8_clear: assert property (@(posedge clk_i) disable iff (rst_i)
            (clr[i] && !set_i[i]) |=> !flag_q[i]);
    end

endmodule

// File: rtl/edge_irq_port.sv
module edge_irq_port
    import eirq_pkg::*;
#(
    parameter int unsigned NPINS        = 8,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned VALID_CYCLES = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [NPINS-1:0] pins_i,
    input  logic             reg_wr_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [NPINS-1:0] reg_wdata_i,
    output logic [NPINS-1:0] reg_rdata_o,
    input  logic             lowpwr_i,
    output logic             irq_o,
    output logic             wake_o
);

    logic [NPINS-1:0] pins_s;
    logic [NPINS-1:0] hits;
    logic [NPINS-1:0] en, pol, flag;

    eirq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (pins_i),
        .q_o   (pins_s)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        eirq_filter #(.VALID_CYCLES(VALID_CYCLES)) u_filt (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .level_i  (pins_s[i]),
            .rising_i (pol[i]),
            .hit_o    (hits[i])
        );
    end

    eirq_regs #(.NPINS(NPINS)) u_regs (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .set_i   (hits),
        .en_o    (en),
        .pol_o   (pol),
        .flag_o  (flag),
        .rdata_o (reg_rdata_o)
    );

    assign irq_o  = |(flag & en);
    assign wake_o = irq_o & lowpwr_i;

    // R11: no wake request without an interrupt request
    a_r11_wake_needs_irq: assert property (@(posedge clk_i) disable iff (rst_i)
        wake_o |-> irq_o);

    // R7: with every enable clear the request stays low
    a_r7_enable_gates: assert property (@(posedge clk_i) disable iff (rst_i)
        (en == '0) |-> !irq_o);

endmodule

// File: tb/edge_irq_port_test.sv
`timescale 1ns/1ps
module edge_irq_port_test;

    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] pins;
    logic          wr;
    logic [1:0]    addr;
    logic [NP-1:0] wdata;
    logic [NP-1:0] rdata;
    logic          lowpwr;
    logic          irq, wake;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    edge_irq_port #(.NPINS(NP), .SYNC_STAGES(2), .VALID_CYCLES(4)) uut (
        .clk_i(clk), .rst_i(rst), .pins_i(pins), .reg_wr_i(wr),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .lowpwr_i(lowpwr), .irq_o(irq), .wake_o(wake)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [NP-1:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // toggle the masked pins for n sampled cycles, then restore and settle
    task automatic pulse(input logic [NP-1:0] mask, input int n);
        @(negedge clk);
        pins = pins ^ mask;
        repeat (n) @(negedge clk);
        pins = pins ^ mask;
        idle(8);
    endtask

    task automatic expect_flags(input string req, input logic [NP-1:0] exp);
        logic [NP-1:0] v;
        rreg(2'd2, v);
        check(req, 32'(v), 32'(exp));
    endtask

    task automatic t_reset();
        logic [NP-1:0] v;
        for (int a = 0; a < 3; a++) begin
            rreg(2'(a), v);
            check("R1 register reset", 32'(v), 0);
        end
        check("R1 irq reset", 32'(irq), 0);
        check("R1 wake reset", 32'(wake), 0);
        // pins sit low, which is active for the reset falling polarity
        idle(12);
        expect_flags("R10 level at reset", 8'h00);
    endtask

    task automatic t_regmap();
        logic [NP-1:0] v;
        wreg(2'd0, 8'hA5);
        rreg(2'd0, v); check("R2 enable readback", 32'(v), 32'hA5);
        wreg(2'd1, 8'hFF);
        rreg(2'd1, v); check("R2 polarity readback", 32'(v), 32'hFF);
        rreg(2'd3, v); check("R2 spare reads zero", 32'(v), 0);
        wreg(2'd0, 8'h00);
        idle(4);
        expect_flags("R2 no flags from config", 8'h00);
    endtask

    task automatic t_valid_and_irq();
        pulse(8'h04, 4);
        expect_flags("R3 four-cycle pulse", 8'h04);
        check("R7 flag without enable gives no irq", 32'(irq), 0);
        wreg(2'd0, 8'h04);
        #1 check("R7 enabled flag raises irq", 32'(irq), 1);
        lowpwr = 1'b0; #1;
        check("R11 wake low when awake", 32'(wake), 0);
        lowpwr = 1'b1; #1;
        check("R11 wake in low power", 32'(wake), 1);
        lowpwr = 1'b0;
        wreg(2'd2, 8'h00);
        expect_flags("R8 zero write keeps flag", 8'h04);
        wreg(2'd2, 8'h04);
        expect_flags("R8 one write clears flag", 8'h00);
        #1 check("R7 irq drops after clear", 32'(irq), 0);
    endtask

    task automatic t_glitch();
        pulse(8'h02, 3);
        expect_flags("R4 three-cycle glitch", 8'h00);
        pulse(8'h02, 1);
        expect_flags("R4 one-cycle glitch", 8'h00);
        pulse(8'h02, 5);
        expect_flags("R3 five-cycle pulse", 8'h02);
        wreg(2'd2, 8'hFF);
    endtask

    task automatic t_multi();
        pulse(8'h81, 4);
        expect_flags("R12 two pins together", 8'h81);
        wreg(2'd2, 8'hFF);
        expect_flags("R8 clear all", 8'h00);
    endtask

    task automatic t_falling();
        wreg(2'd1, 8'hBF);               // pin 6 falling
        @(negedge clk) pins[6] = 1'b1;   // rising edge on a falling pin
        idle(12);
        expect_flags("R5 high level ignored on falling pin", 8'h00);
        pulse(8'h40, 3);
        expect_flags("R5 short low pulse ignored", 8'h00);
        pulse(8'h40, 4);
        expect_flags("R5 four-cycle low pulse", 8'h40);
        wreg(2'd2, 8'h40);
    endtask

    task automatic t_polchange();
        // pin 0 low and inactive under rising; make low the active level
        wreg(2'd1, 8'hBE);
        idle(12);
        expect_flags("R10 polarity change under active level", 8'h00);
        pulse(8'h01, 3);                 // go inactive, then back low and stay
        idle(4);
        expect_flags("R10 fresh falling edge after rearm", 8'h01);
        wreg(2'd2, 8'h01);
    endtask

    task automatic t_hold();
        @(negedge clk) pins[3] = 1'b1;
        idle(10);
        expect_flags("R6 held level sets flag", 8'h08);
        wreg(2'd2, 8'h08);
        idle(12);
        expect_flags("R6 held level does not repeat", 8'h00);
        @(negedge clk) pins[3] = 1'b0;
        idle(8);
        expect_flags("R6 release sets nothing", 8'h00);
    endtask

    task automatic t_set_wins();
        @(negedge clk) pins[2] = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        wr = 1'b1; addr = 2'd2; wdata = 8'h04;   // clear lands in the hit cycle
        @(negedge clk);
        wr = 1'b0; wdata = '0;
        expect_flags("R9 set beats clear", 8'h04);
        wreg(2'd2, 8'h04);
        @(negedge clk) pins[2] = 1'b0;
        idle(8);
        expect_flags("R9 cleared afterwards", 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1; pins = '0; wr = 1'b0; addr = '0; wdata = '0; lowpwr = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_valid_and_irq();
        t_glitch();
        t_multi();
        t_falling();
        t_polchange();
        t_hold();
        t_set_wins();
        idle(4);
        summary();
    end

endmodule